// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block sits beside the execute stage of an in-order five-stage integer pipeline and decides, for each of the two ALU operands, where the operand value should come from. The instruction now in execute names two source registers. The instruction one stage ahead (the memory stage) and the instruction two stages ahead (the write-back stage) may each be about to write a destination register. When a source register matches a pending destination, the operand must come from that later stage and not from the stale register-file read.

The selector is purely combinational and holds no state. It compares each source number against both pending destinations. It ignores producers that do not write and it ignores register 0, which is hard-wired to zero. When both later stages write the same register, the younger result, from the memory stage, takes priority. Each operand produces a 2-bit select that drives a three-way operand multiplexer outside the block. The two operands are decided independently of each other.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage holds a qualifying producer for an operand, that operand's select is 2'b00, which means the register-file value.
- R2: When the memory-stage producer has its write flag set, has a nonzero destination, and that destination equals the operand's source (`src_a` for A, `src_b` for B), the select is 2'b10.
- R3: When the write-back-stage producer has its write flag set, has a nonzero destination equal to the operand's source, and R2 does not apply to that operand, the select is 2'b01.
- R4: A destination of register 0 never causes forwarding, so a source of 0 always yields 2'b00.
- R5: A producer whose write flag is clear never causes forwarding, whatever its destination number.
- R6: When both stages qualify for the same operand, the select is 2'b10. This applies to a chain of back-to-back instructions that each write and read the same register.
- R7: The selects for A and B are decided independently. In the same cycle they may both forward, and they may forward from different stages.
- R8: The select value 2'b11 is never produced.
- R9: The selects depend on the current inputs only. They settle after an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| ex_dst | input | 5 | Destination register number held in the memory stage |
| ex_we | input | 1 | Register-write flag of the memory-stage instruction |
| wb_dst | input | 5 | Destination register number held in the write-back stage |
| wb_we | input | 1 | Register-write flag of the write-back-stage instruction |
| fwd_a | output | 2 | Select for operand A: 00 register file, 10 memory stage, 01 write-back stage |
| fwd_b | output | 2 | Select for operand B, same encoding |

## Verification
The hardest case to reach is the one where both later stages hold a write to the same register that the execute instruction reads. A single dependent pair never produces it. The bench reaches it by replaying a three-instruction chain in which each instruction overwrites and reads the same register, shifting the producers one stage per step, so that the third instruction sees the first two in the write-back and memory stages at once. A second replayed sequence, in which one result feeds four following consumers, covers each distance in turn and also the case where a producer has moved past forwarding range.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int REG_BITS = 5;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_EX  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic ex_hit;
        logic wb_hit;
    } hit_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             we,
    output logic             hit
);

    logic hit_d;

    always_comb begin
        hit_d = 1'b0;
        if (we && (dst != '0) && (dst == src)) begin
            hit_d = 1'b1;
        end
    end

    assign hit = hit_d;

endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  hit_t     hits,
    output fwd_sel_e sel
);

    fwd_sel_e sel_d;

    always_comb begin
        if (hits.ex_hit) begin
            sel_d = SEL_EX;
        end else if (hits.wb_hit) begin
            sel_d = SEL_WB;
        end else begin
            sel_d = SEL_RF;
        end
    end

    assign sel = sel_d;

    always_comb begin
        AST_YOUNGER_WINS: assert (!hits.ex_hit || sel == SEL_EX)
            else $error("memory-stage hit not selected"); // R6
        AST_OLDER_ONLY: assert (!(hits.wb_hit && !hits.ex_hit) || sel == SEL_WB)
            else $error("write-back hit not selected"); // R3
        AST_IDLE_RF: assert (hits.ex_hit || hits.wb_hit || sel == SEL_RF)
            else $error("forward without a hit"); // R1
        AST_NO_ELEVEN: assert (sel != 2'b11)
            else $error("illegal select"); // R8
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = fwd_pkg::REG_BITS
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_we,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_we,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);

    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][REG_W-1:0] src_vec;
    fwd_sel_e                      sel_vec [NUM_OPS];

    assign src_vec[0] = src_a;
    assign src_vec[1] = src_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hit_t hits;

        fwd_match #(.REG_W(REG_W)) i_ex_match (
            .src (src_vec[g]),
            .dst (ex_dst),
            .we  (ex_we),
            .hit (hits.ex_hit)
        );

        fwd_match #(.REG_W(REG_W)) i_wb_match (
            .src (src_vec[g]),
            .dst (wb_dst),
            .we  (wb_we),
            .hit (hits.wb_hit)
        );

        fwd_prio i_prio (
            .hits (hits),
            .sel  (sel_vec[g])
        );

        always_comb begin
            AST_ZERO_SRC: assert (src_vec[g] != '0 || sel_vec[g] == SEL_RF)
                else $error("register 0 forwarded"); // R4
            AST_NO_WRITERS: assert (ex_we || wb_we || sel_vec[g] == SEL_RF)
                else $error("forward with no writer"); // R5
        end
    end

    assign fwd_a = sel_vec[0];
    assign fwd_b = sel_vec[1];

endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;

    logic       clk = 1'b0;
    logic [4:0] src_a, src_b, ex_dst, wb_dst;
    logic       ex_we, wb_we;
    logic [1:0] fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fwd_unit i_fwd_unit (
        .src_a  (src_a),
        .src_b  (src_b),
        .ex_dst (ex_dst),
        .ex_we  (ex_we),
        .wb_dst (wb_dst),
        .wb_we  (wb_we),
        .fwd_a  (fwd_a),
        .fwd_b  (fwd_b)
    );

    task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                         input logic [4:0] ed, input logic ew,
                         input logic [4:0] wd, input logic ww);
        @(negedge clk);
        src_a = sa; src_b = sb; ex_dst = ed; ex_we = ew; wb_dst = wd; wb_we = ww;
        #1;
    endtask

    task automatic expect_sel(input logic [1:0] ea, input logic [1:0] eb, input string req);
        checks++;
        if (fwd_a !== ea || fwd_b !== eb) begin
            errors++;
            $display("FAIL %s: fwd_a=%b fwd_b=%b expected fwd_a=%b fwd_b=%b",
                     req, fwd_a, fwd_b, ea, eb);
        end
    endtask

    task automatic t_idle;
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
        expect_sel(2'b00, 2'b00, "R1 all-zero inputs");
        drive(5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1);
        expect_sel(2'b00, 2'b00, "R1 no match");
    endtask

    task automatic t_ex_fwd;
        drive(5'd9, 5'd4, 5'd9, 1'b1, 5'd0, 1'b0);
        expect_sel(2'b10, 2'b00, "R2 A from memory stage");
        drive(5'd4, 5'd9, 5'd9, 1'b1, 5'd0, 1'b0);
        expect_sel(2'b00, 2'b10, "R2 B from memory stage");
    endtask

    task automatic t_wb_fwd;
        drive(5'd17, 5'd6, 5'd2, 1'b1, 5'd17, 1'b1);
        expect_sel(2'b01, 2'b00, "R3 A from write-back");
        drive(5'd6, 5'd17, 5'd17, 1'b0, 5'd17, 1'b1);
        expect_sel(2'b00, 2'b01, "R3 B from write-back, memory stage not writing");
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        expect_sel(2'b00, 2'b00, "R4 register 0 both stages");
        drive(5'd0, 5'd5, 5'd0, 1'b1, 5'd5, 1'b1);
        expect_sel(2'b00, 2'b01, "R4 zero in memory stage does not mask write-back");
    endtask

    task automatic t_we_off;
        drive(5'd12, 5'd12, 5'd12, 1'b0, 5'd12, 1'b0);
        expect_sel(2'b00, 2'b00, "R5 write flags clear");
    endtask

    task automatic t_mixed;
        drive(5'd3, 5'd8, 5'd3, 1'b1, 5'd8, 1'b1);
        expect_sel(2'b10, 2'b01, "R7 A memory, B write-back");
        drive(5'd8, 5'd3, 5'd3, 1'b1, 5'd8, 1'b1);
        expect_sel(2'b01, 2'b10, "R7 A write-back, B memory");
        drive(5'd3, 5'd3, 5'd3, 1'b1, 5'd8, 1'b1);
        expect_sel(2'b10, 2'b10, "R7 both from memory stage");
    endtask

    // Same register written and read by three consecutive instructions
    task automatic t_double_chain;
        drive(5'd1, 5'd3, 5'd1, 1'b1, 5'd0, 1'b0);
        expect_sel(2'b10, 2'b00, "R6 chain step 2");
        drive(5'd1, 5'd4, 5'd1, 1'b1, 5'd1, 1'b1);
        expect_sel(2'b10, 2'b00, "R6 chain step 3 both stages match");
        drive(5'd7, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);
        expect_sel(2'b00, 2'b10, "R6 both stages match on B");
    endtask

    // One result (r2) feeding four consumers; producers shift one stage per step
    task automatic t_fanout_chain;
        drive(5'd2, 5'd5, 5'd2, 1'b1, 5'd0, 1'b0);
        expect_sel(2'b10, 2'b00, "R2 fanout distance 1");
        drive(5'd6, 5'd2, 5'd12, 1'b1, 5'd2, 1'b1);
        expect_sel(2'b00, 2'b01, "R3 fanout distance 2");
        drive(5'd2, 5'd2, 5'd13, 1'b1, 5'd12, 1'b1);
        expect_sel(2'b00, 2'b00, "R1 fanout distance 3");
        drive(5'd2, 5'd15, 5'd14, 1'b1, 5'd13, 1'b1);
        expect_sel(2'b00, 2'b00, "R1 fanout store");
    endtask

    task automatic t_no_eleven;
        for (int m = 0; m < 16; m++) begin
            drive(5'd10, 5'd11, (m[0] ? 5'd10 : 5'd11), m[1], (m[2] ? 5'd10 : 5'd11), m[3]);
            checks++;
            if (fwd_a === 2'b11 || fwd_b === 2'b11) begin
                errors++;
                $display("FAIL R8: fwd_a=%b fwd_b=%b expected neither 11", fwd_a, fwd_b);
            end
        end
    endtask

    // Inputs change between clock edges and the selects follow
    task automatic t_no_clock;
        @(posedge clk);
        #2;
        src_a = 5'd20; src_b = 5'd21; ex_dst = 5'd20; ex_we = 1'b1; wb_dst = 5'd21; wb_we = 1'b1;
        #1;
        expect_sel(2'b10, 2'b01, "R9 settles without clock edge");
        ex_we = 1'b0;
        #1;
        expect_sel(2'b00, 2'b01, "R9 follows write flag change");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        src_a = '0; src_b = '0; ex_dst = '0; wb_dst = '0; ex_we = 1'b0; wb_we = 1'b0;
        t_idle();
        t_ex_fwd();
        t_wb_fwd();
        t_zero();
        t_we_off();
        t_mixed();
        t_double_chain();
        t_fanout_chain();
        t_no_eleven();
        t_no_clock();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule